// File: doc/BRIEF.md
# Multi-Mode Transmit Serializer Front End

This block turns four lanes of 10-bit, already line-coded characters into four serial bit streams. All of its logic runs on one fast bit clock. The reference clock and the per-lane byte clocks reach the block as plain levels that are sampled on that bit clock. Each lane sends one bit per bit clock. Bit 0 of the parallel word goes out first, and the words follow each other with no gap.

The block chooses by itself which edge captures the parallel words. It looks at two byte-clock inputs to decide. The shared byte clock is lane 2's. The gating byte clock is lane 1's. If the shared clock is quiet, the reference clock captures every lane. The reference may run at one tenth of the bit rate, capturing once per period. It may also run at one twentieth, capturing at each rising edge and again ten bit clocks later. If the shared clock runs and the gating clock is quiet, the shared clock captures every lane. If both run, each lane captures on its own byte clock.

Each captured word goes into a two-entry holding buffer. A per-lane load phase moves words from that buffer into the shift register. While the lock input is low, the load phase follows every capture. Once the lock input is high, the load phase is frozen. This lets the byte clocks wander by two bit times either way without harming the data. A separate output clock runs at one tenth of the bit rate and stays phase-tied to the reference.

Top module: `mmtx_serializer`

## Requirements
- R1: Each lane sends its captured word one bit per bit clock, starting with bit 0 (the bit at index 0 of the lane's 10-bit slice of `tx_word`) and ending with bit 9. The next word's bit 0 follows directly after bit 9.
- R2: While reset is low, every serial output is 1. After reset, a lane's serial output stays at 1 until the first word it has captured begins to be sent.
- R3: When lane 2's byte clock is judged static and `ref_full_rate` is 1, every lane captures `tx_word` on each rising edge of `ref_clk_in`. In this mode the reference period is 10 bit clocks.
- R4: When lane 2's byte clock is judged static and `ref_full_rate` is 0, every lane captures on each rising edge of `ref_clk_in` and again 10 bit clocks after it. In this mode the reference period is 20 bit clocks.
- R5: When lane 2's byte clock is judged toggling and lane 1's is judged static, every lane captures on the rising edges of lane 2's byte clock. The other byte clocks and the reference have no effect on capture.
- R6: When the byte clocks of both lane 1 and lane 2 are judged toggling, each lane captures on the rising edges of its own byte clock.
- R7: Time is split into fixed windows of 64 bit clocks. At the end of each window, a byte-clock input is judged toggling if it showed two or more rising edges in that window. It is judged static if it showed none. With one edge, the previous judgement is kept. Out of reset, both inputs are judged static.
- R8: While `phase_lock` is 0, every capture re-times its lane. A word captured at bit-clock edge e has its bit 0 on the line from edge e+6.
- R9: While `phase_lock` is 1, each lane keeps loading words at the 10-cycle spacing set by its last capture made with the lock low. Captures that drift by up to 2 bit clocks either way from that grid still send every word intact and in order.
- R10: `ref_div_clk` has a period of 10 bit clocks, with 5 high and 5 low, whichever way `ref_full_rate` is set. Its phase restarts at each rising reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_clk_in | input | 1 | Reference clock level, sampled on `clk` |
| ref_full_rate | input | 1 | 1: reference at a tenth of the bit rate; 0: at a twentieth, with a second mid-period capture |
| byte_clk | input | 4 | Per-lane byte clock levels, sampled on `clk`; bit 2 is the shared clock, bit 1 the gating clock |
| phase_lock | input | 1 | 0: load phase tracks captures; 1: load phase frozen |
| tx_word | input | 40 | Lane l's character on bits [10l+9:10l], bit 10l sent first |
| ser_out | output | 4 | Serial line per lane, one bit per `clk` |
| ref_div_clk | output | 1 | Reference-locked clock at a tenth of the bit rate |

## Verification
A wrong capture-source choice shows up on the lines as words swapped for values held from other clock edges. Such errors appear within two detection windows (128 bit clocks) of the byte-clock pattern changing. A broken load phase or holding-buffer pointer shows up in the first word after lock: it arrives shifted, doubled or missing. A frozen phase that quietly keeps tracking stays hidden while the clocks are steady. It only shows up at the first drift step, where a word gets cut short on the line. A wrong idle level or divider count is visible on the outputs from the first cycles after reset.

// File: rtl/mmtx_pkg.sv
package mmtx_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Which edge family captures the parallel words
  typedef enum logic [1:0] {
    SRC_REF    = 2'd0,
    SRC_SHARED = 2'd1,
    SRC_LANE   = 2'd2
  } src_e;
endpackage

// File: rtl/mmtx_activity.sv
module mmtx_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic win_end,
  output logic active
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] edge_cnt;
  logic [1:0] total;

  // saturating count of rising edges seen in this window, including this cycle
  assign total = (edge_cnt == 2'd2) ? 2'd2 : edge_cnt + {1'b0, rise};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= 2'd0;
      active   <= 1'b0;
    end else if (win_end) begin
      edge_cnt <= 2'd0;
      if (total >= 2'd2)
        active <= 1'b1;
      else if (total == 2'd0)
        active <= 1'b0;
    end else if (rise && edge_cnt != 2'd2) begin
      edge_cnt <= edge_cnt + 2'd1;
    end
  end

  // R7
  judged_only_at_window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(active));
endmodule

// File: rtl/mmtx_strobe.sv
module mmtx_strobe
  import mmtx_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int WORD_W      = 10,
  parameter int WIN         = 64,
  parameter int SHARED_LANE = 2,
  parameter int GATE_LANE   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             full_rate,
  input  logic [LANES-1:0] bc_rise,
  output logic [LANES-1:0] strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int MCW = $clog2(WORD_W + 1);

  logic [WCW-1:0] win_cnt;
  logic           win_end;
  logic           shared_act, gate_act;
  logic [MCW-1:0] mid_cnt;
  logic           ref_stb;
  src_e           src;

  assign win_end = (win_cnt == WCW'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else        win_cnt <= win_end ? '0 : win_cnt + 1'b1;
  end

  mmtx_activity u_act_shared (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (bc_rise[SHARED_LANE]),
    .win_end (win_end),
    .active  (shared_act)
  );

  mmtx_activity u_act_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (bc_rise[GATE_LANE]),
    .win_end (win_end),
    .active  (gate_act)
  );

  always_comb begin
    if (!shared_act)    src = SRC_REF;
    else if (!gate_act) src = SRC_SHARED;
    else                src = SRC_LANE;
  end

  // half-rate reference: second capture one word time after each rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mid_cnt <= '0;
    else if (ref_rise)                   mid_cnt <= MCW'(1);
    else if (mid_cnt == MCW'(WORD_W))    mid_cnt <= '0;
    else if (mid_cnt != '0)              mid_cnt <= mid_cnt + 1'b1;
  end

  assign ref_stb = ref_rise | (!full_rate && mid_cnt == MCW'(WORD_W));

  always_comb begin
    for (int g = 0; g < LANES; g++) begin
      case (src)
        SRC_REF:    strobe[g] = ref_stb;
        SRC_SHARED: strobe[g] = bc_rise[SHARED_LANE];
        default:    strobe[g] = bc_rise[g];
      endcase
    end
  end

  // R3
  ref_captures_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shared_act && ref_rise) |-> (&strobe));

  // R5
  shared_captures_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_act && !gate_act) |-> (strobe == {LANES{bc_rise[SHARED_LANE]}}));
endmodule

// File: rtl/mmtx_lane.sv
module mmtx_lane #(
  parameter int WORD_W    = 10,
  parameter int TRACK_DLY = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              lock,
  input  logic [WORD_W-1:0] word,
  output logic              ser
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int             PW       = $clog2(WORD_W);
  localparam logic [PW-1:0]  LAST     = PW'(WORD_W - 1);
  localparam logic [PW-1:0]  TRACK_PH = PW'(WORD_W - 1 - TRACK_DLY);

  logic [WORD_W-1:0] hold [2];
  logic              wr_sel, rd_sel, primed;
  logic [PW-1:0]     phase;
  logic [WORD_W-1:0] shreg;
  logic              track, load;

  assign track = strobe & ~lock;
  assign load  = (phase == LAST) & primed;
  assign ser   = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold[0] <= '0;
      hold[1] <= '0;
      wr_sel  <= 1'b0;
      rd_sel  <= 1'b0;
      primed  <= 1'b0;
      phase   <= '0;
      shreg   <= '1;
    end else begin
      if (strobe) begin
        hold[wr_sel] <= word;
        wr_sel       <= ~wr_sel;
        primed       <= 1'b1;
      end
      if (track) begin
        phase  <= TRACK_PH;
        rd_sel <= wr_sel;
      end else begin
        phase <= (phase == LAST) ? '0 : phase + 1'b1;
        if (load) rd_sel <= ~rd_sel;
      end
      shreg <= load ? hold[rd_sel] : {1'b1, shreg[WORD_W-1:1]};
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> ser);

  // R9
  frozen_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lock) && $past(phase) != LAST) |-> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/mmtx_refdiv.sv
module mmtx_refdiv #(
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  output logic div_clk
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int            PW   = $clog2(WORD_W);
  localparam logic [PW-1:0] LAST = PW'(WORD_W - 1);
  localparam logic [PW-1:0] HALF = PW'(WORD_W / 2);

  logic [PW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (ref_rise)          cnt_nxt = PW'(1);
    else if (cnt == LAST)  cnt_nxt = '0;
    else                   cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_clk <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      div_clk <= (cnt_nxt < HALF);
    end
  end
endmodule

// File: rtl/mmtx_serializer.sv
module mmtx_serializer #(
  parameter int LANES       = 4,
  parameter int WORD_W      = 10,
  parameter int WIN         = 64,
  parameter int SHARED_LANE = 2,
  parameter int GATE_LANE   = 1,
  parameter int TRACK_DLY   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_clk_in,
  input  logic                    ref_full_rate,
  input  logic [LANES-1:0]        byte_clk,
  input  logic                    phase_lock,
  input  logic [LANES*WORD_W-1:0] tx_word,
  output logic [LANES-1:0]        ser_out,
  output logic                    ref_div_clk
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             ref_q;
  logic [LANES-1:0] bc_q;
  logic             ref_rise;
  logic [LANES-1:0] bc_rise;
  logic [LANES-1:0] lane_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      bc_q  <= '0;
    end else begin
      ref_q <= ref_clk_in;
      bc_q  <= byte_clk;
    end
  end

  assign ref_rise = ref_clk_in & ~ref_q;
  assign bc_rise  = byte_clk & ~bc_q;

  mmtx_strobe #(
    .LANES       (LANES),
    .WORD_W      (WORD_W),
    .WIN         (WIN),
    .SHARED_LANE (SHARED_LANE),
    .GATE_LANE   (GATE_LANE)
  ) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_rise  (ref_rise),
    .full_rate (ref_full_rate),
    .bc_rise   (bc_rise),
    .strobe    (lane_strobe)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mmtx_lane #(
      .WORD_W    (WORD_W),
      .TRACK_DLY (TRACK_DLY)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (lane_strobe[g]),
      .lock   (phase_lock),
      .word   (tx_word[g*WORD_W +: WORD_W]),
      .ser    (ser_out[g])
    );
  end

  mmtx_refdiv #(
    .WORD_W (WORD_W)
  ) u_refdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .div_clk  (ref_div_clk)
  );
endmodule

// File: tb/mmtx_serializer_test.sv
module mmtx_serializer_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int L = 4, W = 10, HMAX = 1024, NW = 128;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ref_clk_in, ref_full_rate, phase_lock;
  logic [L-1:0]   byte_clk;
  logic [L*W-1:0] tx_word;
  logic [L-1:0]   ser_out;
  logic           ref_div_clk;

  always #2 clk = ~clk;

  mmtx_serializer uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ref_clk_in    (ref_clk_in),
    .ref_full_rate (ref_full_rate),
    .byte_clk      (byte_clk),
    .phase_lock    (phase_lock),
    .tx_word       (tx_word),
    .ser_out       (ser_out),
    .ref_div_clk   (ref_div_clk)
  );

  int cyc = 0, base = 0;
  always @(posedge clk) cyc = cyc + 1;

  logic hist [L][HMAX];
  logic dhist [HMAX];
  bit   rec = 1'b0;

  always @(negedge clk) begin
    if (rec && (cyc - base) >= 0 && (cyc - base) < HMAX) begin
      for (int l = 0; l < L; l++) hist[l][cyc-base] = ser_out[l];
      dhist[cyc-base] = ref_div_clk;
    end
  end

  int errs = 0, checks = 0;
  bit done = 1'b0;

  // stimulus sources 0..3 are byte clocks, 4 is the reference
  int per [5], hw [5], nxt [5], lr [5], dix [5];
  bit act [5], drf [5];
  int src [L], lu [L], nw [L];
  int we [L][NW];
  logic [W-1:0] ww [L][NW];
  int lock_at;
  bit full;
  int dpat [8] = '{0, 1, 2, 1, 0, -1, -2, -1};

  task automatic chk(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_clk_in = 1'b0; byte_clk = '0; phase_lock = 1'b0;
    tx_word = '0; rec = 1'b0;
    repeat (4) @(negedge clk);
    chk(ser_out == 4'hF, "R2", "lines during reset", int'(ser_out), 15);
    for (int s = 0; s < 5; s++) begin
      act[s] = 1'b0; drf[s] = 1'b0; lr[s] = -1000; dix[s] = 0; nxt[s] = -1;
      per[s] = 10; hw[s] = 5;
    end
    for (int l = 0; l < L; l++) begin nw[l] = 0; lu[l] = -1000; src[l] = 4; end
    rst_n = 1'b1; base = cyc; rec = 1'b1;
  endtask

  task automatic run(int ncyc);
    int e, step;
    bit lock, rs, st;
    bit lvl [5];
    logic [W-1:0] w;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      e = cyc - base + 1;
      lock = (e >= lock_at);
      phase_lock = lock;
      for (int s = 0; s < 5; s++) begin
        if (act[s] && e == nxt[s]) begin
          lr[s] = e;
          step = per[s];
          if (drf[s] && e > lock_at) begin
            step = step + dpat[(dix[s]+1)%8] - dpat[dix[s]%8];
            dix[s]++;
          end
          nxt[s] = e + step;
        end
        lvl[s] = act[s] && e >= lr[s] && (e - lr[s]) < hw[s];
      end
      for (int s = 0; s < L; s++) byte_clk[s] = lvl[s];
      ref_clk_in = lvl[4];
      rs = act[4] && (e == lr[4] || (!full && e == lr[4] + 10));
      for (int l = 0; l < L; l++) begin
        st = (src[l] == 4) ? rs : (act[src[l]] && e == lr[src[l]]);
        if (st && nw[l] < NW) begin
          w = W'($urandom);
          tx_word[l*W +: W] = w;
          we[l][nw[l]] = e;
          ww[l][nw[l]] = w;
          nw[l]++;
          if (!lock) lu[l] = e;
        end
      end
    end
  endtask

  // expected: word loaded at the first frozen-grid point after its capture
  task automatic check_words(string req, int ncyc);
    int e, lref, f;
    logic [W-1:0] got;
    for (int l = 0; l < L; l++) begin
      lref = lu[l] + 6;
      for (int i = 0; i < nw[l]; i++) begin
        e = we[l][i];
        if (e >= lock_at) begin
          f = (e < lref) ? lref : lref + 10 * ((e - lref) / 10 + 1);
          if (f + W < ncyc) begin
            for (int j = 0; j < W; j++) got[j] = hist[l][f+j];
            chk(got == ww[l][i], req, $sformatf("lane %0d word %0d", l, i),
                int'(got), int'(ww[l][i]));
          end
        end
      end
    end
  endtask

  task automatic check_div(string req, int a);
    int rises = 0, highs = 0;
    for (int i = a; i < a + 200; i++) begin
      if (dhist[i]) highs++;
      if (dhist[i] && !dhist[i-1]) rises++;
    end
    chk(rises == 20, req, "divided clock rising edges in 200", rises, 20);
    chk(highs == 100, req, "divided clock high cycles in 200", highs, 100);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int e1, ones;
    logic [W-1:0] got;
    void'($urandom(32'h5EED0001));
    ref_full_rate = 1'b1;
    lock_at = 100000;

    // idle after reset, nothing toggling (R2, R10)
    do_reset(); full = 1'b1; lock_at = 100000;
    run(260);
    ones = 0;
    for (int l = 0; l < L; l++) for (int i = 1; i < 260; i++) if (hist[l][i]) ones++;
    chk(ones == 4 * 259, "R2", "idle high samples", ones, 4 * 259);
    check_div("R10", 40);

    // reference at a tenth of bit rate (R1, R3, R8, R2)
    do_reset(); full = 1'b1; ref_full_rate = 1'b1;
    act[4] = 1'b1; per[4] = 10; hw[4] = 5; nxt[4] = 3; lock_at = 120;
    run(500);
    e1 = we[0][0];
    ones = 0;
    for (int i = 1; i < e1 + 6; i++) if (hist[0][i]) ones++;
    chk(ones == e1 + 5, "R2", "line high before first word", ones, e1 + 5);
    for (int j = 0; j < W; j++) got[j] = hist[0][e1+6+j];
    chk(got == ww[0][0], "R8", "first word six edges after capture", int'(got), int'(ww[0][0]));
    check_words("R1 R3", 500);
    check_div("R10", 250);

    // reference at a twentieth, mid-period capture (R4, R10)
    do_reset(); full = 1'b0; ref_full_rate = 1'b0;
    act[4] = 1'b1; per[4] = 20; hw[4] = 10; nxt[4] = 5; lock_at = 150;
    run(500);
    check_words("R4", 500);
    check_div("R10", 250);

    // shared byte clock, other clocks as distractors (R5, R7)
    do_reset(); full = 1'b1; ref_full_rate = 1'b1;
    act[4] = 1'b1; nxt[4] = 6;
    act[0] = 1'b1; nxt[0] = 4;
    act[3] = 1'b1; nxt[3] = 7;
    act[2] = 1'b1; nxt[2] = 2;
    for (int l = 0; l < L; l++) src[l] = 2;
    lock_at = 250;
    run(600);
    check_words("R5 R7", 600);

    // per-lane clocks with random phases, drift after lock (R6, R7, R9)
    for (int rep = 0; rep < 3; rep++) begin
      do_reset(); full = 1'b1; ref_full_rate = 1'b1;
      act[4] = 1'b1; nxt[4] = 1 + int'($urandom % 10);
      for (int s = 0; s < L; s++) begin
        act[s] = 1'b1;
        nxt[s] = 2 + int'($urandom % 10);
        drf[s] = (rep == 0) ? (s == 0 || s == 3) : bit'($urandom % 2);
        src[s] = s;
      end
      lock_at = 220 + int'($urandom % 80);
      run(800);
      check_words("R6 R7 R9", 800);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule